// File: doc/BRIEF.md
# Port Reset Output Generator

This block produces one active-low reset signal for each downstream port of a switch. Each signal shares a general-purpose pin: it is driven onto that pin only when the port's alternate-function enable is set, and otherwise the pin behaves as ordinary GPIO, with its output value and driver enable taken from the GPIO data and direction inputs. After a chip-level reset, the GPIO configuration keeps the driver off, so the pin floats as an input until software configures it.

In reset-output mode, a two-bit source-select field that all ports share decides what asserts the reset. The reset can follow the slot's power-enable signal or the slot's power-good signal, which are both level sources. It can also be started by a single-cycle hot-reset event on the port. Once the reset is asserted it stays low for a minimum width, even when its cause goes away sooner. That width is a number of clock cycles worked out from a clock-frequency parameter and a pulse-width parameter in microseconds, with a default of 200 µs.

Top module: `prg_reset_out_gen`

## Requirements
- R1: After rst_n is released, every port's reset timer is deasserted, so enabling reset-output mode while the source is inactive drives the pin high at once.
- R2: With cfg_altfn_en[p]=0, pin_out[p] equals gpio_data[p] and pin_oe[p] equals gpio_dir[p], so gpio_dir[p]=0 tri-states the pin.
- R3: With cfg_src_mode=2'b00, the reset is asserted (pin_out low) while slot_pwr_en is low, and released once slot_pwr_en is high and the minimum width has elapsed.
- R4: With cfg_src_mode=2'b01, the reset follows slot_pwr_good low in the same way, and power enable is ignored.
- R5: With cfg_src_mode=2'b10, a one-cycle hot_reset_pulse asserts the reset for exactly MIN_CYCLES cycles, and both power levels are ignored.
- R6: The code cfg_src_mode=2'b11 behaves exactly like 2'b10.
- R7: The reset shows on pin_out after the first rising edge at which the source is sampled active, and it stays low for at least MIN_CYCLES = CLK_FREQ_KHZ*MIN_PULSE_US/1000 cycles, even if the source lasts only one cycle.
- R8: A level source held active for L >= MIN_CYCLES cycles gives a reset that is exactly L cycles wide.
- R9: A hot-reset pulse that arrives while the reset is asserted restarts the full minimum width. This includes a pulse in the last cycle of the count.
- R10: In reset-output mode, pin_oe[p] is 1.
- R11: Each port's reset depends only on that port's own inputs.
- R12: Clearing cfg_altfn_en[p] drops any reset in progress on that port. Setting it again with an inactive source gives a high pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| cfg_altfn_en | input | NUM_PORTS | Per-port select: 1 = reset output, 0 = GPIO |
| cfg_src_mode | input | 2 | Source select: 00 power enable, 01 power good, 10/11 hot reset |
| slot_pwr_en | input | NUM_PORTS | Slot power-enable levels |
| slot_pwr_good | input | NUM_PORTS | Slot power-good levels |
| hot_reset_pulse | input | NUM_PORTS | One-cycle hot-reset events |
| gpio_data | input | NUM_PORTS | GPIO output values |
| gpio_dir | input | NUM_PORTS | GPIO direction, 1 = drive |
| pin_out | output | NUM_PORTS | Pin output value (reset active low) |
| pin_oe | output | NUM_PORTS | Pin driver enable |

## Verification
A restart and an expiry can fall in the same cycle: a hot-reset pulse may be sampled on the very edge at which the width counter reaches zero and would otherwise release the pin. The bench sends a pulse timed to be sampled on the MIN_CYCLES-th edge after the first assertion. It then counts the low cycles that follow. A full further MIN_CYCLES is required, where a design that lets expiry win would release the pin at once. A mid-count restart and single-cycle level dips are measured the same way, by counting low samples.

// File: rtl/prg_pkg.sv
package prg_pkg;
    typedef enum logic [1:0] {
        SRC_PWR_EN   = 2'b00,
        SRC_PWR_GOOD = 2'b01,
        SRC_HOT      = 2'b10,
        SRC_HOT_ALT  = 2'b11
    } src_mode_e;
endpackage

// File: rtl/prg_src_sel.sv
module prg_src_sel
    import prg_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       pwr_en,
    input  logic       pwr_good,
    input  logic       hot_pulse,
    output logic       src_active,
    output logic       retrigger
);
    src_mode_e mode_e;
    assign mode_e = src_mode_e'(mode);

    always_comb begin
        src_active = 1'b0;
        retrigger  = 1'b0;
        unique case (mode_e)
            SRC_PWR_EN:   src_active = ~pwr_en;
            SRC_PWR_GOOD: src_active = ~pwr_good;
            SRC_HOT, SRC_HOT_ALT: begin
                src_active = hot_pulse;
                retrigger  = 1'b1;
            end
            default:      src_active = 1'b0;
        endcase
    end
endmodule

// File: rtl/prg_width_timer.sv
module prg_width_timer #(
    parameter int MIN_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic src_active,
    input  logic retrigger,
    output logic rst_active
);
    localparam int CW = (MIN_CYCLES < 2) ? 1 : $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(MIN_CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] remain;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!enable) begin
            tmr_d = '0;
        end else if (src_active && (!tmr_q.active || retrigger)) begin
            tmr_d.active = 1'b1;
            tmr_d.remain = RELOAD;
        end else if (tmr_q.active) begin
            if (tmr_q.remain != '0) begin
                tmr_d.remain = tmr_q.remain - 1'b1;
            end else if (!src_active) begin
                tmr_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign rst_active = tmr_q.active;
endmodule

// File: rtl/prg_pin_mux.sv
module prg_pin_mux (
    input  logic altfn_en,
    input  logic rst_active,
    input  logic gpio_data,
    input  logic gpio_dir,
    output logic pin_out,
    output logic pin_oe
);
    always_comb begin
        if (altfn_en) begin
            pin_out = ~rst_active;
            pin_oe  = 1'b1;
        end else begin
            pin_out = gpio_data;
            pin_oe  = gpio_dir;
        end
    end
endmodule

// File: rtl/prg_reset_out_gen.sv
module prg_reset_out_gen #(
    parameter int NUM_PORTS    = 4,
    parameter int CLK_FREQ_KHZ = 250000,
    parameter int MIN_PULSE_US = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] cfg_altfn_en,
    input  logic [1:0]           cfg_src_mode,
    input  logic [NUM_PORTS-1:0] slot_pwr_en,
    input  logic [NUM_PORTS-1:0] slot_pwr_good,
    input  logic [NUM_PORTS-1:0] hot_reset_pulse,
    input  logic [NUM_PORTS-1:0] gpio_data,
    input  logic [NUM_PORTS-1:0] gpio_dir,
    output logic [NUM_PORTS-1:0] pin_out,
    output logic [NUM_PORTS-1:0] pin_oe
);
    localparam int RAW_CYCLES = (CLK_FREQ_KHZ * MIN_PULSE_US) / 1000;
    localparam int MIN_CYCLES = (RAW_CYCLES < 1) ? 1 : RAW_CYCLES;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic src_active;
        logic retrigger;
        logic rst_active;

        prg_src_sel u_sel (
            .mode       (cfg_src_mode),
            .pwr_en     (slot_pwr_en[p]),
            .pwr_good   (slot_pwr_good[p]),
            .hot_pulse  (hot_reset_pulse[p]),
            .src_active (src_active),
            .retrigger  (retrigger)
        );

        prg_width_timer #(.MIN_CYCLES(MIN_CYCLES)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (cfg_altfn_en[p]),
            .src_active (src_active),
            .retrigger  (retrigger),
            .rst_active (rst_active)
        );

        prg_pin_mux u_mux (
            .altfn_en   (cfg_altfn_en[p]),
            .rst_active (rst_active),
            .gpio_data  (gpio_data[p]),
            .gpio_dir   (gpio_dir[p]),
            .pin_out    (pin_out[p]),
            .pin_oe     (pin_oe[p])
        );
    end
endmodule

// File: rtl/prg_reset_out_chk.sv
module prg_reset_out_chk #(
    parameter int NUM_PORTS  = 4,
    parameter int MIN_CYCLES = 50000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] cfg_altfn_en,
    input logic [1:0]           cfg_src_mode,
    input logic [NUM_PORTS-1:0] slot_pwr_en,
    input logic [NUM_PORTS-1:0] slot_pwr_good,
    input logic [NUM_PORTS-1:0] hot_reset_pulse,
    input logic [NUM_PORTS-1:0] gpio_data,
    input logic [NUM_PORTS-1:0] gpio_dir,
    input logic [NUM_PORTS-1:0] pin_out,
    input logic [NUM_PORTS-1:0] pin_oe
);
    localparam int CW = (MIN_CYCLES < 2) ? 1 : $clog2(MIN_CYCLES + 1);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        logic [CW-1:0] low_cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                low_cnt <= '0;
            end else if (!cfg_altfn_en[p] || pin_out[p]) begin
                low_cnt <= '0;
            end else if (low_cnt != CW'(MIN_CYCLES)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end

        assert_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_altfn_en[p] && $past(cfg_altfn_en[p]) && $rose(pin_out[p]))
                |-> (low_cnt == CW'(MIN_CYCLES)));

        assert_pwr_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_altfn_en[p] && cfg_src_mode == 2'b00 && !slot_pwr_en[p])
                |=> (!cfg_altfn_en[p] || !pin_out[p]));

        assert_pwr_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_altfn_en[p] && cfg_src_mode == 2'b01 && !slot_pwr_good[p])
                |=> (!cfg_altfn_en[p] || !pin_out[p]));

        assert_hot_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_altfn_en[p] && cfg_src_mode[1] && hot_reset_pulse[p])
                |=> (!cfg_altfn_en[p] || !pin_out[p]));

        assert_drive_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_altfn_en[p] |-> pin_oe[p]);

        assert_gpio_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_altfn_en[p] |-> (pin_out[p] == gpio_data[p] && pin_oe[p] == gpio_dir[p]));
    end
endmodule

bind prg_reset_out_gen prg_reset_out_chk #(
    .NUM_PORTS  (NUM_PORTS),
    .MIN_CYCLES (MIN_CYCLES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_altfn_en    (cfg_altfn_en),
    .cfg_src_mode    (cfg_src_mode),
    .slot_pwr_en     (slot_pwr_en),
    .slot_pwr_good   (slot_pwr_good),
    .hot_reset_pulse (hot_reset_pulse),
    .gpio_data       (gpio_data),
    .gpio_dir        (gpio_dir),
    .pin_out         (pin_out),
    .pin_oe          (pin_oe)
);

// File: tb/sim_prg_reset_out_gen.sv
module sim_prg_reset_out_gen;
    localparam int NP   = 4;
    localparam int FKHZ = 250000;
    localparam int PUS  = 1;
    localparam int MIN  = FKHZ * PUS / 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] altfn = '0;
    logic [1:0]    mode = 2'b00;
    logic [NP-1:0] pen = '1;
    logic [NP-1:0] pg = '1;
    logic [NP-1:0] hot = '0;
    logic [NP-1:0] gd = '0;
    logic [NP-1:0] gdir = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    prg_reset_out_gen #(.NUM_PORTS(NP), .CLK_FREQ_KHZ(FKHZ), .MIN_PULSE_US(PUS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_altfn_en(altfn), .cfg_src_mode(mode),
        .slot_pwr_en(pen), .slot_pwr_good(pg), .hot_reset_pulse(hot),
        .gpio_data(gd), .gpio_dir(gdir), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic       af;
        logic [1:0] md;
        logic       pe;
        logic       pgd;
        logic       dat;
        logic       dir;
        logic       eout;
        logic       eoe;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2},
        '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2},
        '{1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},
        '{1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},
        '{1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
        '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4},
        '{1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input int p, output int n);
        n = 0;
        while (pin_out[p] == 1'b0 && n < 4 * MIN + 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_hot();
        altfn = '1; mode = 2'b10; pen = '1; pg = '1; hot = '0; gd = '0; gdir = '0;
        repeat (MIN + 3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        // reset state: GPIO input, driver off (R2)
        repeat (3) @(negedge clk);
        chk("R2 reset oe", int'(pin_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        altfn = '1; mode = 2'b10;
        #0;
        chk("R1 timers idle after reset", int'(pin_out), (1 << NP) - 1);
        @(negedge clk);
        chk("R1 still high", int'(pin_out), (1 << NP) - 1);

        // table walk
        for (int i = 0; i < 9; i++) begin
            altfn = {NP{VECS[i].af}};
            mode  = VECS[i].md;
            pen   = {NP{VECS[i].pe}};
            pg    = {NP{VECS[i].pgd}};
            gd    = {NP{VECS[i].dat}};
            gdir  = {NP{VECS[i].dir}};
            repeat (MIN + 3) @(negedge clk);
            chk($sformatf("R%0d vec%0d out", VECS[i].req, i), int'(pin_out),
                VECS[i].eout ? (1 << NP) - 1 : 0);
            chk($sformatf("R%0d vec%0d oe", VECS[i].req, i), int'(pin_oe),
                VECS[i].eoe ? (1 << NP) - 1 : 0);
            if (VECS[i].af) chk("R10 oe in reset mode", int'(pin_oe), (1 << NP) - 1);
        end

        // R7: single-cycle power-enable dip gives MIN cycles
        altfn = '1; mode = 2'b00; pen = '1; pg = '1; hot = '0;
        repeat (MIN + 3) @(negedge clk);
        pen[0] = 1'b0;
        @(negedge clk);
        pen[0] = 1'b1;
        measure(0, n);
        chk("R7 short pwr_en dip width", n, MIN);

        // R4: power-good dip, power enable ignored
        mode = 2'b01; pen = '0;
        repeat (MIN + 3) @(negedge clk);
        chk("R4 pwr_en ignored", int'(pin_out), (1 << NP) - 1);
        pg[2] = 1'b0;
        @(negedge clk);
        pg[2] = 1'b1;
        measure(2, n);
        chk("R4 pwr_good dip width", n, MIN);

        // R8: level held 3*MIN cycles
        pen = '1;
        repeat (MIN + 3) @(negedge clk);
        pg[1] = 1'b0;
        @(negedge clk);
        repeat (3 * MIN - 1) @(negedge clk);
        chk("R8 low at end of long level", int'(pin_out[1]), 0);
        pg[1] = 1'b1;
        @(negedge clk);
        chk("R8 released on first inactive edge", int'(pin_out[1]), 1);

        // R5 / R11: hot pulse on port 1 only
        idle_hot();
        hot[1] = 1'b1;
        @(negedge clk);
        hot[1] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 other ports untouched", int'(pin_out & 4'b1101), 4'b1101);
        measure(1, n);
        chk("R5 hot pulse width", n + 5, MIN);

        // R6: reserved code behaves as hot reset
        mode = 2'b11;
        @(negedge clk);
        hot[3] = 1'b1;
        @(negedge clk);
        hot[3] = 1'b0;
        measure(3, n);
        chk("R6 reserved mode width", n, MIN);

        // R9: restart mid-count
        idle_hot();
        hot[0] = 1'b1;
        @(negedge clk);
        hot[0] = 1'b0;
        repeat (99) @(negedge clk);
        hot[0] = 1'b1;
        @(negedge clk);
        hot[0] = 1'b0;
        measure(0, n);
        chk("R9 restart mid-count", n, MIN);

        // R9: pulse coincident with expiry
        idle_hot();
        hot[2] = 1'b1;
        @(negedge clk);
        hot[2] = 1'b0;
        repeat (MIN - 1) @(negedge clk);
        chk("R9 low on last counted cycle", int'(pin_out[2]), 0);
        hot[2] = 1'b1;
        @(negedge clk);
        hot[2] = 1'b0;
        measure(2, n);
        chk("R9 restart at expiry", n, MIN);

        // R12: leaving reset-output mode drops the assertion
        idle_hot();
        hot[3] = 1'b1;
        @(negedge clk);
        hot[3] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R12 asserted before switch", int'(pin_out[3]), 0);
        altfn[3] = 1'b0; gd[3] = 1'b1; gdir[3] = 1'b1;
        #0;
        chk("R12 gpio value shown", int'(pin_out[3]), 1);
        @(negedge clk);
        altfn[3] = 1'b1;
        #0;
        chk("R12 pending reset discarded", int'(pin_out[3]), 1);
        @(negedge clk);
        chk("R12 stays released", int'(pin_out[3]), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule